// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block runs ahead of the instruction decoder. It reads the code stream from memory as whole 32-bit doublewords at rising, doubleword-aligned addresses, and it keeps the bytes in a 16-byte circular queue. The decoder takes bytes from the head of the queue through a valid/ready port, one byte per cycle. The queue works on bytes only. A returned doubleword can hold the end of one instruction and the start of the next, and the block does not care.

The block shares the memory bus with the execution side. It raises a one-cycle-decidable request with an address. An external arbiter grants it, and the read data comes back some cycles later with a valid strobe. At most one prefetch read is in flight at a time. A pending data access from the execution side always wins: while it is asserted, the prefetch request is held low. A new read is issued only when at least four bytes of queue space are free, so a returned doubleword always fits.

A control transfer pulses the redirect input with a target byte address. This does three things:
- It empties the queue.
- It restarts fetching at the doubleword that contains the target.
- It discards any read response still in flight.

If the target is not doubleword-aligned, the bytes of the first doubleword that lie below the target are dropped.

Top module: `ifetch_queue`

## Requirements
- R1: While reset is asserted and right after it, `q_count` is 0, `dec_valid` is low and `bus_req` is low. Fetching starts at address 0.
- R2: `bus_req` is low in every cycle in which `data_req` is high.
- R3: `bus_req` is high only when no prefetch read is outstanding and `q_count` is at most 12. With the decoder stalled, the queue fills to 16 minus the byte offset of the redirect target, and then stops requesting.
- R4: `bus_addr` is always doubleword-aligned. After a redirect it equals the target with its low two bits cleared. Each granted request (`bus_req` and `bus_gnt` high at a clock edge) advances it by 4.
- R5: Returned data is little-endian: the byte at address A is `bus_rdata[8*(A%4)+7 : 8*(A%4)]` of the doubleword fetched from A with its low two bits cleared. The bytes popped by the decoder are the memory bytes at strictly ascending consecutive addresses.
- R6: `q_count` never exceeds 16.
- R7: In the cycle after `flush` is high, `q_count` is 0 and `dec_valid` is low. A pop offered in the flush cycle is not taken.
- R8: A read response that belongs to a request granted before a redirect is discarded. It does not raise `q_count`.
- R9: After a redirect to target T, the first byte popped is the memory byte at T, even when T is not doubleword-aligned.
- R10: A pop happens when `dec_valid` and `dec_ready` are both high. With no write in the same cycle, `q_count` drops by exactly one.
- R11: `dec_valid` is high exactly when `q_count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect pulse: empty the queue and restart fetching |
| flush_addr | input | ADDR_W | Byte address of the redirect target |
| data_req | input | 1 | Execution-side data access pending; takes priority over prefetch |
| bus_req | output | 1 | Prefetch read request |
| bus_addr | output | ADDR_W | Doubleword-aligned prefetch address |
| bus_gnt | input | 1 | Arbiter grant; a request is taken when `bus_req` and `bus_gnt` are both high |
| bus_rvalid | input | 1 | Read data of the outstanding request is present |
| bus_rdata | input | 32 | Returned doubleword, little-endian |
| dec_byte | output | 8 | Byte at the head of the queue |
| dec_valid | output | 1 | Head byte is valid |
| dec_ready | input | 1 | Decoder takes the head byte |
| q_count | output | $clog2(QBYTES+1) | Number of bytes held |

## Verification
A bad write pointer or skip value shows up as a wrong byte in the popped stream on the very next pop. The bench compares every popped byte against an address-derived memory model, so this is caught at once.

If a stale response were kept, the first bytes after a redirect would carry old-address data. Together with the count check after a stale delivery, that fault surfaces within the cycles it takes to pop them.

Count or address drift shows up differently. Either `q_count` stops agreeing with `dec_valid` and with the fill level expected under a stalled decoder, or a granted address differs from the bench's own running fetch address in that same cycle.

// File: rtl/ifetch_queue.sv
module ifetch_queue #(
  parameter int ADDR_W = 32,
  parameter int QBYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [ADDR_W-1:0]            flush_addr,
  input  logic                         data_req,
  output logic                         bus_req,
  output logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_gnt,
  input  logic                         bus_rvalid,
  input  logic [31:0]                  bus_rdata,
  output logic [7:0]                   dec_byte,
  output logic                         dec_valid,
  input  logic                         dec_ready,
  output logic [$clog2(QBYTES+1)-1:0]  q_count
);
  localparam int PW = $clog2(QBYTES);
  localparam int CW = $clog2(QBYTES+1);
  localparam logic [CW-1:0] ROOM = CW'(QBYTES - 4);

  logic [7:0]        qmem [QBYTES];
  logic [PW-1:0]     rd_p, wr_p;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] fa;
  logic              pend, stale;
  logic [1:0]        skip;

  wire       accept = bus_rvalid && pend && !stale && !flush;
  wire [2:0] wr_n   = accept ? (3'd4 - {1'b0, skip}) : 3'd0;
  wire       pop    = dec_valid && dec_ready && !flush;
  wire       grant  = bus_req && bus_gnt;

  assign bus_req   = rst_n && !data_req && !flush && !pend && (cnt <= ROOM);
  assign bus_addr  = fa;
  assign dec_valid = (cnt != '0);
  assign dec_byte  = qmem[rd_p];
  assign q_count   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt   <= '0;
      fa    <= '0;
      pend  <= 1'b0;
      stale <= 1'b0;
      skip  <= 2'd0;
    end else if (flush) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt   <= '0;
      fa    <= {flush_addr[ADDR_W-1:2], 2'b00};
      skip  <= flush_addr[1:0];
      pend  <= pend && !bus_rvalid;
      stale <= pend && !bus_rvalid;
    end else begin
      if (grant) begin
        fa   <= fa + ADDR_W'(4);
        pend <= 1'b1;
      end
      if (bus_rvalid) begin
        pend  <= 1'b0;
        stale <= 1'b0;
      end
      if (accept) skip <= 2'd0;
      wr_p <= wr_p + PW'(wr_n);
      rd_p <= rd_p + PW'(pop);
      cnt  <= cnt + CW'(wr_n) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < 4; i++) begin
        if (i >= int'(skip))
          qmem[wr_p + PW'(i - int'(skip))] <= bus_rdata[8*i +: 8];
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (q_count == '0) && !dec_valid);
  assert_data_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !bus_req);
  assert_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (q_count <= ROOM));
  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1:0] == 2'b00);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (bus_addr == $past(bus_addr) + ADDR_W'(4)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(QBYTES));
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_count == '0) && !dec_valid);
  assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && stale && !dec_ready) |=> (q_count <= $past(q_count)));
  assert_pop_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && !flush && !bus_rvalid) |=> (q_count == $past(q_count) - CW'(1)));
  assert_valid_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid == (q_count != '0));
endmodule

// File: tb/ifetch_queue_bench.sv
module ifetch_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] flush_addr = '0;
  logic        data_req = 1'b0;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic        bus_gnt = 1'b0;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [7:0]  dec_byte;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [4:0]  q_count;

  always #5 clk = ~clk;

  ifetch_queue u_ifetch_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .data_req(data_req), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .dec_byte(dec_byte), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .q_count(q_count)
  );

  int checks = 0, fails = 0;
  logic [31:0] rng = 32'h1357_9bdf;
  logic [31:0] exp_a = '0, nf = '0, raddr = '0;
  bit rp = 0, rstale = 0, was_flush = 0, first_pop = 0, stale_del = 0, pop_chk = 0;
  int rcnt = 0;
  logic [4:0] prev_qc = '0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'((a * 7) ^ (a >> 5));
  endfunction

  function automatic logic [31:0] word(input logic [31:0] a);
    return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
  endfunction

  task automatic rnd(output logic [31:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic step(input bit f, input logic [31:0] fadd, input bit dr,
                      input bit rdy, input bit g);
    bit outstanding, delivered_stale;
    @(negedge clk);
    flush = f; flush_addr = fadd; data_req = dr; dec_ready = rdy; bus_gnt = g;
    outstanding = rp;
    delivered_stale = 0;
    if (rp && rcnt == 0) begin
      bus_rvalid = 1'b1; bus_rdata = word(raddr); rp = 0;
      delivered_stale = rstale;
    end else begin
      bus_rvalid = 1'b0; bus_rdata = '0;
      if (rp) rcnt--;
    end
    #1;
    if (was_flush) chk(q_count == 0 && !dec_valid, "R7", "count after flush", 32'(q_count), 0);
    if (stale_del) chk(q_count <= prev_qc, "R8", "stale response kept", 32'(q_count), 32'(prev_qc));
    if (pop_chk) chk(q_count == prev_qc - 5'd1, "R10", "count after pop", 32'(q_count), 32'(prev_qc - 5'd1));
    chk(dec_valid == (q_count != 0), "R11", "valid vs count", 32'(dec_valid), 32'(q_count != 0));
    chk(q_count <= 16, "R6", "count bound", 32'(q_count), 16);
    if (dr) chk(!bus_req, "R2", "request under data priority", 32'(bus_req), 0);
    if (bus_req) chk(q_count <= 12 && !outstanding, "R3", "request room/outstanding", 32'(q_count), 12);
    if (f) begin
      exp_a = fadd; nf = {fadd[31:2], 2'b00}; first_pop = 1;
      if (rp) rstale = 1;
    end else if (dec_valid && rdy) begin
      if (first_pop) chk(dec_byte == mb(exp_a), "R9", "first byte after redirect", 32'(dec_byte), 32'(mb(exp_a)));
      else chk(dec_byte == mb(exp_a), "R5", "popped byte", 32'(dec_byte), 32'(mb(exp_a)));
      exp_a++; first_pop = 0;
    end
    if (bus_req && g) begin
      chk(bus_addr == nf && bus_addr[1:0] == 0, "R4", "fetch address", bus_addr, nf);
      nf += 4; rp = 1; rstale = 0; raddr = bus_addr;
      rnd(rng); rcnt = int'(rng % 3);
    end
    was_flush = f;
    stale_del = delivered_stale && !f && !rdy;
    pop_chk = dec_valid && rdy && !f && !bus_rvalid;
    prev_qc = q_count;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] tgt;
    repeat (3) @(negedge clk);
    #1;
    chk(q_count == 0 && !dec_valid && !bus_req, "R1", "reset state", 32'(q_count), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(bus_addr == 0, "R1", "start address", bus_addr, 0);
    for (int k = 0; k < 8; k++) begin
      tgt = 32'h100 + 32'(k * 9);
      step(1, tgt, 0, 0, 1);
      for (int c = 0; c < 40; c++) begin
        rnd(r);
        step(0, '0, r[3:0] == 0, 0, r[4] | r[5]);
      end
      @(negedge clk); #1;
      chk(q_count == 5'(16 - int'(tgt[1:0])) && !bus_req, "R3", "stalled fill level",
          32'(q_count), 32'(16 - int'(tgt[1:0])));
      for (int c = 0; c < 160; c++) begin
        rnd(r);
        if (r[7:0] < 6) step(1, 32'h2000 + {24'd0, r[15:8]}, 0, r[16], 1);
        else step(0, '0, r[9:8] == 0, r[10] | r[11], r[12] | r[13]);
      end
    end
    for (int c = 0; c < 200; c++) step(0, '0, 0, 1, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule